// File: doc/BRIEF.md
# Three-Wire Serial Slave Port with Select-Gated Start

This block is an 8-bit synchronous serial port that runs as a slave. An external master drives the serial clock. The port drives a data output and reads a data input. On the processor side it has a transmit buffer, a receive register, a mode register, a busy flag and a completion flag. No transfer is started by an explicit "go" command. In full-duplex mode, writing the transmit buffer starts the transfer. In receive-only mode, reading the receive register starts the next reception.

An active-low select input can be enabled. When it is enabled, the select input gates when a requested transfer may begin. It can also freeze a transfer that is already running, so that shifting resumes where it stopped. The serial clock and the select input are brought into the system clock domain through two-flop synchronizers. Clock edges are detected on the synchronized copy.

Top module: `tws_port`

## Requirements
- R1: A transfer moves DATA_W bits, most significant bit first. `sdo` takes the next transmit bit after a falling `sck` edge. `sdi` is sampled after a rising `sck` edge. After completion `rx_data` holds the received byte, with the first bit received in bit 7, and `sdo` returns high.
- R2: With `mode_duplex`=1 stored, a `tx_wr` pulse while not busy starts a transfer that sends `tx_data`. `busy` reads 1 from the following cycle.
- R3: With `mode_duplex`=0 stored, an `rx_rd` pulse starts a reception and `tx_wr` starts nothing. During a reception `sdo` stays high.
- R4: With `mode_sel_en`=1 stored and `ss_n` low, a start request begins the transfer at once.
- R5: With `mode_sel_en`=1 stored and `ss_n` high, a start request is held pending and `busy` stays 0. The transfer begins after `ss_n` goes low.
- R6: If `ss_n` goes high during a transfer with select enabled, `sck` edges are ignored, `busy` stays 1 and `sdo` holds. Shifting resumes after `ss_n` returns low.
- R7: On the last rising `sck` edge of a transfer, `busy` clears and `irq` sets in the same cycle.
- R8: While `busy`=1, writes to the transmit buffer, writes to the mode register and start requests have no effect.
- R9: `irq` stays set until an `irq_clr` pulse or an accepted start request clears it.
- R10: With `mode_sel_en`=0 stored, `ss_n` has no effect on starting or shifting.
- R11: After reset: `busy`=0, `irq`=0, `sdo`=1, `rx_data`=0, duplex mode on, select off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | DATA_W | Transmit buffer write data |
| rx_rd | input | 1 | Receive register read strobe |
| rx_data | output | DATA_W | Receive register contents |
| mode_wr | input | 1 | Mode register write strobe |
| mode_duplex | input | 1 | Mode field: 1 selects full duplex, 0 selects receive only |
| mode_sel_en | input | 1 | Mode field: 1 enables select gating |
| irq_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion flag |
| sck | input | 1 | Serial clock from the master, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ss_n | input | 1 | Active-low select |

## Verification
The hardest case to reach is a select-driven pause in the middle of a byte. To reach it, the stimulus raises `ss_n` after the third bit while `sck` is high. It then runs two full dummy `sck` cycles with inverted data. After that it lowers `ss_n` and finishes the byte. The pause is correct only if both the received byte and the transmitted bits are unaffected by the dummy cycles. A second hard case is a request made while deselected. The bench holds `ss_n` high across the buffer write, confirms that `busy` stays low, and only then releases the select.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RUN  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic duplex;
        logic sel_en;
    } mode_t;

    localparam mode_t MODE_RESET = '{duplex: 1'b1, sel_en: 1'b0};

    function automatic logic rise_of(input logic now, input logic prev);
        return now & ~prev;
    endfunction

    function automatic logic fall_of(input logic now, input logic prev);
        return ~now & prev;
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int unsigned     W       = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= RST_VAL;
                else     stg[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= RST_VAL;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              mode_wr,
    input  mode_t             mode_in,
    input  logic              irq_clr,
    input  logic              ss_active,
    input  logic              done,
    output logic              busy,
    output logic              irq,
    output logic              gate,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              run_duplex
);
    xfer_state_e       state_q, state_d;
    mode_t             mode_q;
    logic [DATA_W-1:0] tx_buf_q, tx_next;
    logic              req, accept, open_q;

    assign open_q     = (state_q != ST_RUN);
    assign req        = mode_q.duplex ? tx_wr : rx_rd;
    assign accept     = req && open_q;
    assign gate       = !mode_q.sel_en || ss_active;
    assign tx_next    = (tx_wr && open_q) ? tx_data : tx_buf_q;
    assign busy       = (state_q == ST_RUN);
    assign run_duplex = mode_q.duplex;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = gate ? ST_RUN : ST_PEND;
            ST_PEND: if (gate)   state_d = ST_RUN;
            ST_RUN:  if (done)   state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    assign load      = (state_d == ST_RUN) && (state_q != ST_RUN);
    assign load_data = mode_q.duplex ? tx_next : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_RESET;
            tx_buf_q <= '0;
            irq      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mode_wr && open_q) mode_q   <= mode_in;
            if (tx_wr && open_q)   tx_buf_q <= tx_data;
            if (done)                     irq <= 1'b1;
            else if (accept || irq_clr)   irq <= 1'b0;
        end
    end

    // R8: register contents frozen while a transfer runs
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_q) && $stable(tx_buf_q)));

    // R9: flag holds without a clear or an accepted start
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr && !accept) |=> irq);

    // R5: pending request does not raise busy while deselected
    p_pend_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PEND && !gate) |=> !busy);
endmodule

// File: rtl/tws_shift.sv
module tws_shift
    import tws_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              gate,
    input  logic              sck_s,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word,
    output logic              done
);
    localparam int unsigned CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [CW-1:0]     cnt;
    logic              active, sck_prev, rise, fall, step;

    assign rise = rise_of(sck_s, sck_prev);
    assign fall = fall_of(sck_s, sck_prev);
    assign step = active && gate;
    assign done = step && rise && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b1;
            tx_sh    <= '0;
            rx_word  <= '0;
            cnt      <= '0;
            active   <= 1'b0;
            sdo      <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            if (load) begin
                tx_sh  <= load_data;
                cnt    <= '0;
                active <= 1'b1;
            end else if (step) begin
                if (fall) begin
                    sdo   <= tx_sh[DATA_W-1];
                    tx_sh <= tx_sh << 1;
                end
                if (rise) begin
                    rx_word <= {rx_word[DATA_W-2:0], sdi};
                    cnt     <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        active <= 1'b0;
                        sdo    <= 1'b1;
                    end
                end
            end
        end
    end

    // R6: no progress while the select gate is closed
    p_pause_r6: assert property (@(posedge clk) disable iff (rst)
        (active && !gate && !load) |=> ($stable(cnt) && $stable(rx_word) && $stable(sdo)));
endmodule

// File: rtl/tws_port.sv
module tws_port
    import tws_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    input  logic              mode_wr,
    input  logic              mode_duplex,
    input  logic              mode_sel_en,
    input  logic              irq_clr,
    output logic              busy,
    output logic              irq,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    input  logic              ss_n
);
    logic [1:0]        pins_s;
    logic              gate, load, done, run_duplex;
    logic [DATA_W-1:0] load_data;
    mode_t             mode_in;

    assign mode_in = '{duplex: mode_duplex, sel_en: mode_sel_en};

    tws_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, ss_n}),
        .q   (pins_s)
    );

    tws_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .rx_rd      (rx_rd),
        .mode_wr    (mode_wr),
        .mode_in    (mode_in),
        .irq_clr    (irq_clr),
        .ss_active  (~pins_s[0]),
        .done       (done),
        .busy       (busy),
        .irq        (irq),
        .gate       (gate),
        .load       (load),
        .load_data  (load_data),
        .run_duplex (run_duplex)
    );

    tws_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .gate      (gate),
        .sck_s     (pins_s[1]),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_word   (rx_data),
        .done      (done)
    );

    // R7: completion raises the flag as busy drops
    p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R3: receive-only transfers keep the output high
    p_rxonly_sdo_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !run_duplex) |-> sdo);
endmodule

// File: tb/sim_tws_port.sv
module sim_tws_port;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 4;
    localparam int  DW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_wr = 1'b0, rx_rd = 1'b0, mode_wr = 1'b0, irq_clr = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          mode_duplex = 1'b1, mode_sel_en = 1'b0;
    logic          sck = 1'b1, sdi = 1'b0, ss_n = 1'b1;
    logic [DW-1:0] rx_data;
    logic          busy, irq, sdo;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q [$];
    logic busy_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tws_port #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .mode_wr(mode_wr), .mode_duplex(mode_duplex),
        .mode_sel_en(mode_sel_en), .irq_clr(irq_clr), .busy(busy), .irq(irq),
        .sck(sck), .sdi(sdi), .sdo(sdo), .ss_n(ss_n)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pops the expected receive byte on each completion
    always @(negedge clk) begin
        if (!rst && busy_prev && !busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected completion", 0, 1);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R1 received byte", int'(rx_data), int'(e));
            end
            check(irq == 1'b1, "R7 irq at completion", int'(irq), 1);
            check(sdo == 1'b1, "R1 sdo idles high after done", int'(sdo), 1);
        end
        busy_prev = busy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx(input logic [DW-1:0] v);
        tx_data = v; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask
    task automatic pulse_rd();
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    endtask
    task automatic pulse_mode(input logic d, input logic s);
        mode_duplex = d; mode_sel_en = s; mode_wr = 1'b1; tick(1); mode_wr = 1'b0;
    endtask
    task automatic pulse_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    task automatic pause_seq(input logic bitv);
        logic held;
        ss_n = 1'b1; tick(HALF);
        held = sdo;
        for (int k = 0; k < 2; k++) begin
            sck = 1'b0; sdi = ~bitv; tick(HALF);
            sck = 1'b1; tick(HALF);
        end
        check(busy == 1'b1, "R6 busy held in pause", int'(busy), 1);
        check(sdo == held, "R6 sdo held in pause", int'(sdo), int'(held));
        ss_n = 1'b0; tick(6);
    endtask

    // driver: pushes expected receive byte, clocks the byte as master
    task automatic xfer(input logic [DW-1:0] tx_exp, input logic [DW-1:0] rx_val,
                        input int pause_at, input string req);
        logic [DW-1:0] got;
        exp_q.push_back(rx_val);
        for (int i = 0; i < DW; i++) begin
            if (i == pause_at) pause_seq(rx_val[DW-1-i]);
            sck = 1'b0; sdi = rx_val[DW-1-i]; tick(HALF);
            got[DW-1-i] = sdo;
            sck = 1'b1; tick(HALF);
        end
        tick(4);
        check(got == tx_exp, req, int'(got), int'(tx_exp));
        check(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R11 reset state
        check(busy == 1'b0 && irq == 1'b0, "R11 busy/irq after reset", int'({busy, irq}), 0);
        check(sdo == 1'b1, "R11 sdo after reset", int'(sdo), 1);
        check(rx_data == '0, "R11 rx_data after reset", int'(rx_data), 0);

        // R2 duplex start on buffer write
        pulse_tx(8'hA5);
        check(busy == 1'b1, "R2 busy after tx write", int'(busy), 1);
        xfer(8'hA5, 8'h3C, -1, "R1 transmitted bits msb first");

        // R9 flag holds then clears on strobe
        tick(10);
        check(irq == 1'b1, "R9 irq held", int'(irq), 1);
        pulse_clr();
        check(irq == 1'b0, "R9 irq cleared by strobe", int'(irq), 0);

        // R8 writes while busy ignored
        pulse_tx(8'h0F);
        pulse_tx(8'hF0);
        pulse_mode(1'b0, 1'b1);
        pulse_rd();
        xfer(8'h0F, 8'h81, -1, "R8 tx data kept during busy write");
        check(irq == 1'b1, "R7 irq after transfer", int'(irq), 1);
        pulse_tx(8'h55);
        check(busy == 1'b1, "R8 mode unchanged, start immediate", int'(busy), 1);
        check(irq == 1'b0, "R9 irq cleared by new start", int'(irq), 0);
        xfer(8'h55, 8'hAA, -1, "R8 next transfer data");

        // R3 receive-only mode
        pulse_mode(1'b0, 1'b0);
        pulse_tx(8'h12);
        tick(3);
        check(busy == 1'b0, "R3 tx write does not start", int'(busy), 0);
        pulse_rd();
        check(busy == 1'b1, "R3 read starts reception", int'(busy), 1);
        xfer(8'hFF, 8'h6B, -1, "R3 sdo high during reception");

        // R4 select enabled, selected: immediate
        pulse_mode(1'b1, 1'b1);
        ss_n = 1'b0; tick(4);
        pulse_tx(8'hC3);
        check(busy == 1'b1, "R4 immediate start when selected", int'(busy), 1);
        xfer(8'hC3, 8'h5A, -1, "R4 transfer data");

        // R5 request while deselected is pending
        ss_n = 1'b1; tick(4);
        pulse_tx(8'h96);
        tick(4);
        check(busy == 1'b0, "R5 pending keeps busy low", int'(busy), 0);
        ss_n = 1'b0; tick(5);
        check(busy == 1'b1, "R5 starts after select low", int'(busy), 1);
        tick(2);
        xfer(8'h96, 8'hE1, -1, "R5 pending transfer data");

        // R6 pause mid-transfer
        pulse_tx(8'h3E);
        xfer(8'h3E, 8'hE7, 3, "R6 transfer data across pause");

        // R10 select disabled: ss_n ignored
        pulse_mode(1'b1, 1'b0);
        ss_n = 1'b1; tick(4);
        pulse_tx(8'h71);
        check(busy == 1'b1, "R10 start despite ss_n high", int'(busy), 1);
        xfer(8'h71, 8'h19, -1, "R10 shifting despite ss_n high");

        tick(4);
        check(exp_q.size() == 0, "R1 all transfers completed", exp_q.size(), 0);
        summary();
    end
endmodule